// File: doc/BRIEF.md
# Address Latch with Step Unit

This block sits on the address path of a small 8-bit-style processor. It captures a 16-bit value from the shared internal address bus into a latch, feeds that latched value through a combined up/down stepper, and routes one of several sources out to the external address pins. The same stepped result can be driven back onto the internal bus, so the classic "fetch, then advance the program counter" loop closes through the bus: the stepper output goes onto the bus and the latch loads it again in the same cycle.

The stepper adds or subtracts a carry-in of one or zero, and the direction is chosen every cycle. A narrow-carry mode confines the step to the low seven bits, which suits a refresh counter that shares a register pair with an instruction register. A clear input forces the result to zero so that the program counter or the refresh pair can be reset through the normal data path. A flag reports when the value on the address pins is exactly one.

Top module: `addr_path_unit`

## Requirements
- R1: With `rst_n` low at a rising clock edge the latch becomes 0x0000, whatever `latch_we` is doing.
- R2: With `latch_we` high at a rising edge the latch takes the value on `abus`; with it low the latch keeps its value.
- R3: With `step_en` high, `dec_mode` low and the other modes off, the stepped value is latch + 1 modulo 2^16 (0x1234 gives 0x1235, 0xFFFF gives 0x0000).
- R4: With `step_en` high and `dec_mode` high, the stepped value is latch − 1 modulo 2^16 (0x0000 gives 0xFFFF).
- R5: With `step_en` low the stepped value equals the latch, in either direction.
- R6: With `limit_low` high, bits 6:0 step modulo 128 in the selected direction and bits 15:7 keep their latched value (0x12FF up gives 0x1280, 0x1280 down gives 0x12FF).
- R7: With `force_zero` high the stepped value is 0x0000, overriding `step_en`, `dec_mode` and `limit_low`.
- R8: `addr_pins` shows the value on `abus` when `pin_sel_bus` is high; otherwise the stepped value when `pin_sel_inc` is high; otherwise the latch. The pins follow these inputs in the same cycle.
- R9: With `bus_oe` high the block drives the stepped value onto `abus`. With it low the block leaves `abus` at high impedance, so a value driven by another source reads back unchanged.
- R10: `addr_is_one` is high exactly when `addr_pins` equals 0x0001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| abus | inout | 16 | Shared internal address bus |
| latch_we | input | 1 | Load the latch from `abus` |
| dec_mode | input | 1 | 1 = step down, 0 = step up |
| step_en | input | 1 | Carry-in: 1 = step by one, 0 = pass through |
| limit_low | input | 1 | Confine the step to bits 6:0 |
| force_zero | input | 1 | Force the stepped value to zero |
| pin_sel_inc | input | 1 | Put the stepped value on the pins |
| pin_sel_bus | input | 1 | Put the bus value on the pins (wins over `pin_sel_inc`) |
| bus_oe | input | 1 | Drive the stepped value onto `abus` |
| addr_pins | output | 16 | External address |
| addr_is_one | output | 1 | High when `addr_pins` is 0x0001 |

## Verification
The only state is the latch, so a wrong latched value shows on `addr_pins` in the cycle after the bad load whenever the latch or stepper source is selected. A fault in the stepper or the mode priority shows in the same cycle the controls are applied. The carry boundaries (all ones going up, zero going down, bit 6 to bit 7 in narrow mode) are the places where a cut or leaking carry shows as a wrong upper byte. The bus read-back after a stepped write-back shows whether the bus driver and the latch agree on the value.

// File: rtl/addr_path_pkg.sv
// Shared types for the address path unit.
// Assumes: nothing beyond IEEE 1800-2017.
package addr_path_pkg;

    // Source shown on the external address pins
    typedef enum logic [1:0] {
        PIN_FROM_LATCH = 2'd0,
        PIN_FROM_STEP  = 2'd1,
        PIN_FROM_BUS   = 2'd2
    } pin_src_e;

endpackage

// File: rtl/addr_latch.sv
// Address latch: holds one address word loaded from the internal bus.
// Assumes: synchronous active-low reset that wins over the load enable.
module addr_latch #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);

    // Capture the bus on load, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (q == '0));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(d)));

    // R2
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));

endmodule

// File: rtl/addr_stepper.sv
// Up/down stepper: adds or subtracts a one-bit carry-in to the latched
// address, with a narrow mode that cuts the carry above the low field and
// a clear that forces zero.
// Assumes: LOW_W < ADDR_W; clear has the highest priority.
module addr_stepper #(
    parameter int ADDR_W = 16,
    parameter int LOW_W  = 7
) (
    input  logic [ADDR_W-1:0] a,
    input  logic              dec,
    input  logic              carry_in,
    input  logic              narrow,
    input  logic              clear,
    output logic [ADDR_W-1:0] y
);

    localparam int HIGH_W = ADDR_W - LOW_W;

    logic [ADDR_W-1:0] full_step;
    logic [LOW_W-1:0]  low_step;
    logic [ADDR_W-1:0] wide_cin;
    logic [LOW_W-1:0]  narrow_cin;

    // Widen the carry-in for each adder
    assign wide_cin   = {{(ADDR_W-1){1'b0}}, carry_in};
    assign narrow_cin = {{(LOW_W-1){1'b0}}, carry_in};

    // Full-width and low-field adders in the chosen direction
    always_comb begin
        full_step = dec ? (a - wide_cin) : (a + wide_cin);
        low_step  = dec ? (a[LOW_W-1:0] - narrow_cin) : (a[LOW_W-1:0] + narrow_cin);
    end

    // Pick the result: clear, then narrow, then full width
    always_comb begin
        if (clear)
            y = '0;
        else if (narrow)
            y = {a[ADDR_W-1:ADDR_W-HIGH_W], low_step};
        else
            y = full_step;
    end

endmodule

// File: rtl/addr_pin_mux.sv
// Pin source selector: routes the latch, stepper or bus word to the pins.
// Assumes: the select is one of the encoded pin sources.
module addr_pin_mux
    import addr_path_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  pin_src_e          sel,
    input  logic [ADDR_W-1:0] latch_val,
    input  logic [ADDR_W-1:0] step_val,
    input  logic [ADDR_W-1:0] bus_val,
    output logic [ADDR_W-1:0] y
);

    // Route the selected source
    always_comb begin
        unique case (sel)
            PIN_FROM_STEP: y = step_val;
            PIN_FROM_BUS:  y = bus_val;
            default:       y = latch_val;
        endcase
    end

endmodule

// File: rtl/addr_path_unit.sv
// Address path unit: latch from the internal bus, up/down stepper,
// pin selector, bus write-back driver and an address-equals-one flag.
// Assumes: only one source drives abus at a time; synchronous active-low reset.
module addr_path_unit
    import addr_path_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LOW_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    inout  wire  [ADDR_W-1:0] abus,
    input  logic              latch_we,
    input  logic              dec_mode,
    input  logic              step_en,
    input  logic              limit_low,
    input  logic              force_zero,
    input  logic              pin_sel_inc,
    input  logic              pin_sel_bus,
    input  logic              bus_oe,
    output logic [ADDR_W-1:0] addr_pins,
    output logic              addr_is_one
);

    localparam logic [ADDR_W-1:0] ONE_VAL = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] bus_rd;
    logic [ADDR_W-1:0] latch_q;
    logic [ADDR_W-1:0] step_val;
    pin_src_e          pin_sel;

    // Read side of the shared bus
    assign bus_rd = abus;

    // Write-back driver, high impedance when not enabled
    assign abus = bus_oe ? step_val : {ADDR_W{1'bz}};

    addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (latch_we),
        .d     (bus_rd),
        .q     (latch_q)
    );

    addr_stepper #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_step (
        .a        (latch_q),
        .dec      (dec_mode),
        .carry_in (step_en),
        .narrow   (limit_low),
        .clear    (force_zero),
        .y        (step_val)
    );

    // Encode the pin source, bus select first
    always_comb begin
        if (pin_sel_bus)
            pin_sel = PIN_FROM_BUS;
        else if (pin_sel_inc)
            pin_sel = PIN_FROM_STEP;
        else
            pin_sel = PIN_FROM_LATCH;
    end

    addr_pin_mux #(.ADDR_W(ADDR_W)) u_mux (
        .sel       (pin_sel),
        .latch_val (latch_q),
        .step_val  (step_val),
        .bus_val   (bus_rd),
        .y         (addr_pins)
    );

    // Flag a pin address of exactly one
    assign addr_is_one = (addr_pins == ONE_VAL);

    // R7
    zero_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_zero |-> (step_val == '0));

    // R6
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_low && !force_zero) |-> (step_val[ADDR_W-1:LOW_W] == latch_q[ADDR_W-1:LOW_W]));

    // R5
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !force_zero) |-> (step_val == latch_q));

    // R9
    bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (abus == step_val));

    // R10
    one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_is_one |-> ($countones(addr_pins) == 1 && addr_pins[0]));

endmodule

// File: tb/addr_path_unit_test.sv
`timescale 1ns/1ps
module addr_path_unit_test;

    localparam int  W        = 16;
    localparam real HALF_PER = 4.0;   // 125 MHz

    logic         clk = 1'b0;
    logic         rst_n;
    logic         latch_we, dec_mode, step_en, limit_low, force_zero;
    logic         pin_sel_inc, pin_sel_bus, bus_oe;
    logic         tb_drv;
    logic [W-1:0] tb_val;
    wire  [W-1:0] abus;
    logic [W-1:0] addr_pins;
    logic         addr_is_one;

    assign abus = tb_drv ? tb_val : {W{1'bz}};

    always #(HALF_PER) clk = ~clk;

    addr_path_unit uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .abus        (abus),
        .latch_we    (latch_we),
        .dec_mode    (dec_mode),
        .step_en     (step_en),
        .limit_low   (limit_low),
        .force_zero  (force_zero),
        .pin_sel_inc (pin_sel_inc),
        .pin_sel_bus (pin_sel_bus),
        .bus_oe      (bus_oe),
        .addr_pins   (addr_pins),
        .addr_is_one (addr_is_one)
    );

    typedef struct {
        logic [W-1:0] pins;
        logic         one;
        logic         chk_bus;
        logic [W-1:0] bus;
        string        tag;
    } exp_t;

    exp_t         sb_q[$];
    logic [W-1:0] model_latch;
    int           n_checks = 0;
    int           n_errors = 0;
    bit           done = 0;

    // Reference stepper built from the requirements
    function automatic logic [W-1:0] ref_step(input logic [W-1:0] a, input logic dn,
                                              input logic st, input logic lim, input logic zr);
        logic [W-1:0] r;
        logic [6:0]   lo;
        if (zr) return '0;
        if (lim) begin
            lo = dn ? (a[6:0] - 7'(st)) : (a[6:0] + 7'(st));
            r  = {a[W-1:7], lo};
        end else begin
            r = dn ? (a - W'(st)) : (a + W'(st));
        end
        return r;
    endfunction

    // Driver: apply one cycle of controls and queue the expected outputs
    task automatic drive(input logic we, input logic dn, input logic st, input logic lim,
                         input logic zr, input logic s_inc, input logic s_bus, input logic oe,
                         input logic drv, input logic [W-1:0] val, input string tag);
        exp_t         e;
        logic [W-1:0] adj, busv;
        @(negedge clk);
        latch_we = we; dec_mode = dn; step_en = st; limit_low = lim; force_zero = zr;
        pin_sel_inc = s_inc; pin_sel_bus = s_bus; bus_oe = oe; tb_drv = drv; tb_val = val;
        adj  = ref_step(model_latch, dn, st, lim, zr);
        busv = oe ? adj : val;
        e.pins    = s_bus ? busv : (s_inc ? adj : model_latch);
        e.one     = (e.pins == 16'h0001);
        e.chk_bus = oe || drv;
        e.bus     = busv;
        e.tag     = tag;
        sb_q.push_back(e);
        if (we && (oe || drv)) model_latch = busv;
    endtask

    // Monitor: compare outputs mid-cycle, before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (addr_pins !== e.pins || addr_is_one !== e.one) begin
                    n_errors++;
                    $display("FAIL %s: pins=%h one=%b expected pins=%h one=%b",
                             e.tag, addr_pins, addr_is_one, e.pins, e.one);
                end
                if (e.chk_bus) begin
                    n_checks++;
                    if (abus !== e.bus) begin
                        n_errors++;
                        $display("FAIL %s bus: abus=%h expected %h", e.tag, abus, e.bus);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(200000 * 2 * HALF_PER);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Stimulus sequence
    initial begin
        rst_n = 1'b0; latch_we = 1'b0; dec_mode = 1'b0; step_en = 1'b0; limit_low = 1'b0;
        force_zero = 1'b0; pin_sel_inc = 1'b0; pin_sel_bus = 1'b0; bus_oe = 1'b0;
        tb_drv = 1'b0; tb_val = '0; model_latch = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 R10: step from 0 while loading 0x1234; pins show 0x0001 and flag
        drive(1,0,1,0,0, 1,0,0, 1,16'h1234, "R10 R8 step of cleared latch");
        // R3: 0x1234 + 1 = 0x1235
        drive(0,0,1,0,0, 1,0,0, 0,'0, "R3 increment 1234");
        // R4: 0x1234 - 1
        drive(0,1,1,0,0, 1,0,0, 0,'0, "R4 decrement 1234");
        // R5: no carry-in, both directions
        drive(0,1,0,0,0, 1,0,0, 0,'0, "R5 pass-through down");
        drive(0,0,0,0,0, 1,0,0, 0,'0, "R5 pass-through up");
        // R2 R9: no load while another source drives; bus reads its value
        drive(0,0,1,0,0, 0,0,0, 1,16'hAAAA, "R2 R9 hold, external bus value");
        // R8: bus source wins over stepper select
        drive(0,0,1,0,0, 1,1,0, 1,16'h5A5A, "R8 bus to pins");
        drive(0,0,0,0,0, 0,0,0, 0,'0, "R2 latch still 1234");

        // R3 R4: wrap at the ends
        drive(1,0,0,0,0, 0,0,0, 1,16'hFFFF, "R2 load FFFF");
        drive(0,0,1,0,0, 1,0,0, 0,'0, "R3 wrap FFFF up");
        drive(1,0,0,0,0, 0,0,0, 1,16'h0000, "R2 load 0000");
        drive(0,1,1,0,0, 1,0,0, 0,'0, "R4 wrap 0000 down");

        // R6: narrow mode on the bit 6 / bit 7 boundary
        drive(1,0,0,0,0, 0,0,0, 1,16'h12FF, "R2 load 12FF");
        drive(0,0,1,1,0, 1,0,0, 0,'0, "R6 narrow up 12FF");
        drive(1,0,0,0,0, 0,0,0, 1,16'h1280, "R2 load 1280");
        drive(0,1,1,1,0, 1,0,0, 0,'0, "R6 narrow down 1280");

        // R7: clear overrides step, direction and narrow mode
        drive(0,1,1,1,1, 1,0,0, 0,'0, "R7 clear with all modes");
        drive(0,0,1,0,1, 1,0,0, 0,'0, "R7 clear with step up");

        // R9: write-back onto the bus and reload in the same cycle
        drive(1,0,1,0,0, 0,0,1, 0,'0, "R9 write-back 1280+1");
        drive(0,0,0,0,0, 0,0,0, 0,'0, "R9 latch took write-back");
        drive(0,0,0,0,0, 0,1,1, 0,'0, "R9 R8 driven bus to pins");

        // R10: flag only for exactly one
        drive(1,0,0,0,0, 0,0,0, 1,16'h0002, "R2 load 0002");
        drive(0,1,1,0,0, 1,0,0, 0,'0, "R10 stepped to one");
        drive(0,0,0,0,0, 0,0,0, 0,'0, "R10 two is not one");
        drive(0,0,0,0,0, 0,1,0, 1,16'h8001, "R10 8001 is not one");

        // R1: reset wins over a load, latch clears
        @(negedge clk);
        rst_n = 1'b0; latch_we = 1'b1; tb_drv = 1'b1; tb_val = 16'hBEEF; bus_oe = 1'b0;
        pin_sel_inc = 1'b0; pin_sel_bus = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; latch_we = 1'b0; tb_drv = 1'b0;
        model_latch = '0;
        drive(0,0,0,0,0, 0,0,0, 0,'0, "R1 latch cleared by reset");
        drive(0,0,1,0,0, 1,0,0, 0,'0, "R1 R3 step after reset");

        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule